// File: doc/BRIEF.md
# Mains zero-crossing pulse generator

This block turns three digitised mains phase polarity bits into one timing strobe for a host controller. Each phase input is a sign bit from an external comparator, sampled by the system clock. The block cleans each bit, measures the interval between its rising crossings, and marks a phase as usable only when that interval looks like mains. One usable phase is chosen as the timing source. A pulse of fixed width is issued at each of that phase's rising crossings.

When no phase is usable, the block keeps the host supplied with a strobe. It switches to an internal reference that runs at a fixed rate (54 Hz by default) and uses the same pulse width. The host can therefore always lock a software timer to the strobe, whether mains is present or not.

All timing values (pulse width, valid period window, loss timeout, fallback rate) are given in microseconds or hertz. They are turned into cycle counts from the clock frequency parameter at elaboration.

Top module: `mains_zc_pulser`

## Requirements
- R1: While reset is asserted, and directly after it is released, `zc_pulse` is low.
- R2: Every pulse on `zc_pulse` stays high for exactly PULSE_US microseconds of clock cycles (150 cycles in the bench configuration), then goes low.
- R3: While a phase is the selected source, one pulse starts a fixed small number of cycles after each low-to-high transition of that phase's input (between 6 and 24 cycles in the bench). A high-to-low transition never starts a pulse.
- R4: A phase becomes usable when two consecutive rising crossings are spaced between PERIOD_MIN_US and PERIOD_MAX_US inclusive (1500 to 2500 cycles in the bench). A rising crossing with a spacing outside that window makes the phase unusable.
- R5: A phase becomes unusable once LOSS_US passes with no rising crossing (4000 cycles in the bench).
- R6: The selected phase is kept for as long as it remains usable. When it stops being usable, selection moves to the lowest-numbered usable phase.
- R7: When no phase is usable, pulses are issued every CLK_HZ/REF_HZ cycles from an internal counter (1851 cycles in the bench).
- R8: A level change on a phase input is accepted only after DEGLITCH consecutive equal samples. A spike shorter than that (7 cycles with DEGLITCH = 8) creates no pulse and does not disturb validity.
- R9: A pulse in progress is never shortened or restarted, whether a new trigger arrives or the block changes between phase and fallback mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_sign | input | NPH | Polarity bit of each mains phase, 1 = positive half-cycle |
| zc_pulse | output | 1 | Timing strobe, high for the pulse width at each crossing or reference tick |

## Verification
The bench builds the block with CLK_HZ = 100000. At that setting a millisecond is 100 cycles: the mains periods, the 40 ms loss timeout and the 54 Hz fallback period all become a few thousand cycles. This lets the bench step through exact boundary periods (1499, 1500, 2500, 2501 cycles) and every change of source and mode in one short run. DEGLITCH stays at 8, so the bench can inject spikes of seven samples, the longest that must still be rejected. Using two phases offset by 600 cycles, the bench can tell from pulse timing alone which phase is driving the output.

// File: rtl/zc_pkg.sv
package zc_pkg;

   // Convert a duration in microseconds to clock cycles (truncating).
   function automatic longint us_to_cyc(input longint clk_hz, input longint dur_us);
      return (clk_hz * dur_us) / 64'd1000000;
   endfunction

   // Cycles in one period of a frequency given in hertz.
   function automatic longint hz_to_cyc(input longint clk_hz, input longint freq_hz);
      return clk_hz / freq_hz;
   endfunction

endpackage

// File: rtl/zc_deglitch.sv
module zc_deglitch #(
   parameter int unsigned STAGES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic level,
   output logic rise
);
   logic meta_q, sync_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= 1'b0;
         sync_q <= 1'b0;
      end else begin
         meta_q <= raw_in;
         sync_q <= meta_q;
      end
   end

   generate
      if (STAGES <= 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               level <= 1'b0;
               rise  <= 1'b0;
            end else begin
               level <= sync_q;
               rise  <= sync_q & ~level;
            end
         end
      end else begin : g_filter
         localparam int unsigned CW = $clog2(STAGES);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               level <= 1'b0;
               rise  <= 1'b0;
               run_q <= '0;
            end else begin
               rise <= 1'b0;
               if (sync_q == level) begin
                  run_q <= '0;
               end else if (run_q == CW'(STAGES - 1)) begin
                  level <= sync_q;
                  rise  <= sync_q;
                  run_q <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/zc_phase_judge.sv
module zc_phase_judge #(
   parameter int unsigned PMIN_CYC = 1500,
   parameter int unsigned PMAX_CYC = 2500,
   parameter int unsigned LOSS_CYC = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   output logic valid
);
   localparam int unsigned CW = $clog2(LOSS_CYC + 1);

   logic [CW-1:0] gap_q;
   logic          seen_q;
   logic [CW:0]   elapsed;
   logic          in_window;

   assign elapsed   = {1'b0, gap_q} + 1'b1;
   assign in_window = (elapsed >= (CW+1)'(PMIN_CYC)) && (elapsed <= (CW+1)'(PMAX_CYC));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
         valid  <= 1'b0;
      end else if (rise) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
         valid  <= seen_q & in_window;
      end else if (gap_q == CW'(LOSS_CYC - 1)) begin
         seen_q <= 1'b0;
         valid  <= 1'b0;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end
endmodule

// File: rtl/zc_source_sel.sv
module zc_source_sel #(
   parameter int unsigned NPH  = 3,
   parameter int unsigned SELW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPH-1:0]  valid,
   output logic [SELW-1:0] sel,
   output logic            fallback
);
   logic [SELW-1:0] lowest;

   always_comb begin
      lowest = '0;
      for (int i = NPH - 1; i >= 0; i--) begin
         if (valid[i]) lowest = SELW'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel      <= '0;
         fallback <= 1'b1;
      end else if (|valid) begin
         if (fallback || !valid[sel]) sel <= lowest;
         fallback <= 1'b0;
      end else begin
         fallback <= 1'b1;
      end
   end
endmodule

// File: rtl/zc_pulse_gen.sv
module zc_pulse_gen #(
   parameter int unsigned PULSE_CYC = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse
);
   localparam int unsigned PW = $clog2(PULSE_CYC + 1);

   logic [PW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse  <= 1'b0;
         left_q <= '0;
      end else if (pulse) begin
         if (left_q == '0) pulse <= 1'b0;
         else              left_q <= left_q - 1'b1;
      end else if (trig) begin
         pulse  <= 1'b1;
         left_q <= PW'(PULSE_CYC - 1);
      end
   end
endmodule

// File: rtl/mains_zc_pulser.sv
module mains_zc_pulser #(
   parameter int unsigned NPH           = 3,
   parameter longint      CLK_HZ        = 50_000_000,
   parameter int unsigned PULSE_US      = 1500,
   parameter int unsigned PERIOD_MIN_US = 15000,
   parameter int unsigned PERIOD_MAX_US = 25000,
   parameter int unsigned LOSS_US       = 40000,
   parameter int unsigned REF_HZ        = 54,
   parameter int unsigned DEGLITCH      = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NPH-1:0] phase_sign,
   output logic           zc_pulse
);
   localparam int unsigned PULSE_CYC = int'(zc_pkg::us_to_cyc(CLK_HZ, PULSE_US));
   localparam int unsigned PMIN_CYC  = int'(zc_pkg::us_to_cyc(CLK_HZ, PERIOD_MIN_US));
   localparam int unsigned PMAX_CYC  = int'(zc_pkg::us_to_cyc(CLK_HZ, PERIOD_MAX_US));
   localparam int unsigned LOSS_CYC  = int'(zc_pkg::us_to_cyc(CLK_HZ, LOSS_US));
   localparam int unsigned REF_CYC   = int'(zc_pkg::hz_to_cyc(CLK_HZ, REF_HZ));
   localparam int unsigned SELW      = (NPH > 1) ? $clog2(NPH) : 1;
   localparam int unsigned RW        = $clog2(REF_CYC);

   generate
      if (NPH < 1) begin : g_bad_nph
         $error("NPH must be at least 1");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("pulse width rounds to zero cycles");
      end
      if (PMIN_CYC >= PMAX_CYC) begin : g_bad_window
         $error("valid period window is empty");
      end
      if (PMAX_CYC >= LOSS_CYC) begin : g_bad_loss
         $error("loss timeout must exceed the longest valid period");
      end
      if (PULSE_CYC >= PMIN_CYC || PULSE_CYC >= REF_CYC) begin : g_bad_ratio
         $error("pulse must be shorter than any period");
      end
   endgenerate

   logic [NPH-1:0]  ph_level;
   logic [NPH-1:0]  ph_rise;
   logic [NPH-1:0]  ph_valid;
   logic [SELW-1:0] src_sel;
   logic            fb_mode;
   logic            trig;
   logic [RW-1:0]   ref_cnt;
   logic            ref_tick;

   for (genvar k = 0; k < NPH; k++) begin : g_phase
      zc_deglitch #(.STAGES(DEGLITCH)) u_dg (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_in (phase_sign[k]),
         .level  (ph_level[k]),
         .rise   (ph_rise[k])
      );
      zc_phase_judge #(
         .PMIN_CYC (PMIN_CYC),
         .PMAX_CYC (PMAX_CYC),
         .LOSS_CYC (LOSS_CYC)
      ) u_judge (
         .clk   (clk),
         .rst_n (rst_n),
         .rise  (ph_rise[k]),
         .valid (ph_valid[k])
      );
   end

   zc_source_sel #(.NPH(NPH), .SELW(SELW)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (ph_valid),
      .sel      (src_sel),
      .fallback (fb_mode)
   );

   // free-running reference used whenever no phase qualifies
   assign ref_tick = (ref_cnt == RW'(REF_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)        ref_cnt <= '0;
      else if (ref_tick) ref_cnt <= '0;
      else               ref_cnt <= ref_cnt + 1'b1;
   end

   assign trig = fb_mode ? ref_tick : (ph_rise[src_sel] & ph_valid[src_sel]);

   zc_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (trig),
      .pulse (zc_pulse)
   );

   logic unused_level;
   assign unused_level = ^ph_level;
endmodule

// File: rtl/zc_pulser_chk.sv
module zc_pulser_chk #(
   parameter int unsigned NPH       = 3,
   parameter int unsigned SELW      = 2,
   parameter int unsigned PULSE_CYC = 150
) (
   input logic            clk,
   input logic            rst_n,
   input logic            zc_pulse,
   input logic [NPH-1:0]  ph_valid,
   input logic [NPH-1:0]  ph_rise,
   input logic [SELW-1:0] src_sel,
   input logic            fb_mode,
   input logic            trig
);
   logic [31:0] high_run;

   always_ff @(posedge clk) begin
      if (!rst_n)        high_run <= '0;
      else if (zc_pulse) high_run <= high_run + 1;
      else               high_run <= '0;
   end

   AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      zc_pulse |-> (high_run < PULSE_CYC)); // R2

   AST_PULSE_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
      (zc_pulse && (high_run < PULSE_CYC - 1)) |=> zc_pulse); // R9

   AST_TRIG_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !fb_mode) |-> ph_valid[src_sel]); // R3

   AST_SEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!fb_mode && ph_valid[src_sel]) |=> (src_sel == $past(src_sel))); // R6

   AST_FALLBACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_mode && !$past(fb_mode)) |-> ($past(ph_valid) == '0)); // R7

   for (genvar k = 0; k < NPH; k++) begin : g_chk
      AST_VALID_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ph_valid[k]) |-> $past(ph_rise[k])); // R4
   end
endmodule

bind mains_zc_pulser zc_pulser_chk #(
   .NPH       (NPH),
   .SELW      (SELW),
   .PULSE_CYC (PULSE_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .zc_pulse (zc_pulse),
   .ph_valid (ph_valid),
   .ph_rise  (ph_rise),
   .src_sel  (src_sel),
   .fb_mode  (fb_mode),
   .trig     (trig)
);

// File: tb/tb_mains_zc_pulser.sv
module tb_mains_zc_pulser;
   localparam longint CLK_HZ  = 100_000;
   localparam int     PULSE   = 150;
   localparam int     REF_CYC = 1851;
   localparam int     LAT_MIN = 6;
   localparam int     LAT_MAX = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] phase_sign = '0;
   logic       zc_pulse;

   mains_zc_pulser #(.NPH(3), .CLK_HZ(CLK_HZ)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase_sign (phase_sign),
      .zc_pulse   (zc_pulse)
   );

   always #10 clk = ~clk;

   int     vectors = 0;
   int     fails = 0;
   bit     done = 1'b0;
   longint cyc = 0;
   int     per [3] = '{2000, 2000, 2000};
   int     ctr [3] = '{0, 0, 0};
   bit     en  [3] = '{0, 0, 0};
   bit     gl  [3] = '{0, 0, 0};
   longint last_edge [3] = '{-100000, -100000, -100000};
   int     exp_src = -2;   // -2 don't care, -1 fallback, k phase k
   longint rise_at = 0;
   longint last_pulse = 0;
   bit     prev_fb = 1'b0;
   bit     seen_rise = 1'b0;
   logic   out_prev = 1'b0;
   int     npulse = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // stimulus and output monitor, both away from the active edge
   always @(negedge clk) begin
      for (int k = 0; k < 3; k++) begin
         logic lvl;
         lvl = 1'b0;
         if (en[k]) begin
            ctr[k] = (ctr[k] + 1 >= per[k]) ? 0 : ctr[k] + 1;
            lvl = (ctr[k] >= per[k] / 2);
            if (ctr[k] == per[k] / 2) last_edge[k] = cyc;
            if (gl[k] && ctr[k] >= 100 && ctr[k] <= 106) lvl = 1'b1;
         end
         phase_sign[k] = lvl;
      end
      if (zc_pulse && !out_prev) begin
         npulse++;
         if (exp_src >= 0) begin
            longint d;
            d = cyc - last_edge[exp_src];
            check(d >= LAT_MIN && d <= LAT_MAX, "R3/R6",
                  $sformatf("pulse offset from phase %0d edge", exp_src), d, LAT_MIN);
         end
         if (exp_src == -1) begin
            if (prev_fb)
               check(cyc - last_pulse == REF_CYC, "R7", "fallback spacing",
                     cyc - last_pulse, REF_CYC);
            prev_fb = 1'b1;
         end else begin
            prev_fb = 1'b0;
         end
         last_pulse = cyc;
         rise_at = cyc;
         seen_rise = 1'b1;
      end
      if (!zc_pulse && out_prev && seen_rise)
         check(cyc - rise_at == PULSE, "R2/R9", "pulse width", cyc - rise_at, PULSE);
      out_prev = zc_pulse;
   end

   task automatic settle(input int n);
      exp_src = -2;
      prev_fb = 1'b0;
      repeat (n) @(posedge clk);
   endtask

   task automatic window(input int mode, input int n, input int min_p, input string req);
      exp_src = mode;
      npulse = 0;
      repeat (n) @(posedge clk);
      check(npulse >= min_p, req, $sformatf("pulse count, mode %0d", mode), npulse, min_p);
      exp_src = -2;
   endtask

   task automatic finish_up;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(zc_pulse == 1'b0, "R1", "output during reset", zc_pulse, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(zc_pulse == 1'b0, "R1", "output after reset", zc_pulse, 0);

      // no phase present: internal reference
      settle(2000);
      window(-1, 8000, 4, "R7");

      // phase 0 at a nominal period
      per[0] = 2000; en[0] = 1'b1;
      settle(7000);
      window(0, 10000, 5, "R3/R4");

      // period window edges
      per[0] = 1499;
      settle(5000);
      window(-1, 6000, 3, "R4 short period");
      per[0] = 1500;
      settle(5000);
      window(0, 6000, 3, "R4 min period");
      per[0] = 2501;
      settle(6000);
      window(-1, 6000, 3, "R4 long period");
      per[0] = 2500;
      settle(6000);
      window(0, 7500, 3, "R4 max period");

      // two phases, 600 cycles apart, with spikes on both
      per[0] = 2000;
      per[1] = 2000;
      ctr[1] = (ctr[0] + 600) % 2000;
      en[1]  = 1'b1;
      gl[0]  = 1'b1;
      gl[1]  = 1'b1;
      settle(6000);
      window(0, 6000, 2, "R6/R8");

      // phase 0 lost: selection moves to phase 1
      en[0] = 1'b0;
      settle(6000);
      window(1, 6000, 2, "R5/R6");

      // phase 0 returns: selection stays on phase 1
      ctr[0] = (ctr[1] + 1400) % 2000;
      en[0]  = 1'b1;
      settle(5000);
      window(1, 6000, 2, "R6 sticky");

      // phase 1 lost: back to the lowest usable phase
      en[1] = 1'b0;
      settle(6000);
      window(0, 6000, 2, "R6 reselect");

      // everything lost: fallback again
      en[0] = 1'b0;
      settle(6000);
      window(-1, 8000, 4, "R5/R7");

      done = 1'b1;
      finish_up();
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         finish_up();
      end
   end
endmodule